// File: doc/BRIEF.md
# PWM Timer Tick-Enable Generator

This block produces the count-enable strobes for a five-channel PWM timer. Two shared prescalers divide the system clock. Each channel then applies its own power-of-two divider to its prescaler's strobe, or it takes a synchronised external tick input instead. The channel counters downstream advance only in cycles where their strobe is high. Those counters and the bus protocol that writes the registers are not part of this block.

Two configuration words are written through a one-cycle write strobe:

- **Prescale word**: holds one divide value for each prescaler.
- **Select word**: holds a 4-bit code for each channel.

A write to either word restarts every prescaler and divider counter from zero. The new setting therefore produces its first strobe after exactly one full divided period.

Top module: `pwmtick_gen`

## Requirements
- R1: While reset is held, every tick output is 0. After reset both configuration words are 0, so every channel divides by 1 and its tick is high in every cycle.
- R2: Prescale word bits 7:0 hold value p0 and bits 15:8 hold value p1. Channels 0 and 1 use p0. Channels 2 to 4 use p1. A value p divides the clock by p+1.
- R3: Channel n reads its 4-bit code from select-word bits 4n+3:4n. A non-external code c divides the prescaler strobe by 2^min(c+DIV_BASE, 4). The default DIV_BASE is 0, so codes 5 to 15 divide by 16.
- R4: For a divided channel with prescale value p and exponent s, the first tick appears (p+1)*2^s cycles after the write edge. Later ticks repeat at that period, and each tick lasts one cycle.
- R5: Codes flagged in the EXT_CODES parameter select an external tick. By default only code 4 is flagged. Channels 0 and 1 take ext_i[0] and channels 2 to 4 take ext_i[1].
- R6: An external rising edge produces a tick in the third cycle after it, one cycle wide. A held high level and a falling edge produce no tick.
- R7: A configuration write restarts all prescaler and divider counters. No divided channel ticks in the cycle after the write edge, even if a tick was due then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_addr | input | 1 | Write target: 0 = prescale word, 1 = select word |
| cfg_wdata | input | 20 | Write data, sized to the wider of the two words |
| ext_i | input | 2 | Asynchronous external tick inputs, one per prescaler group |
| tick_o | output | 5 | Per-channel single-cycle tick-enable strobes |

## Verification
The case that needs care is a configuration write landing in the same cycle that a divided channel would have produced its tick. The bench restarts a channel whose period is four cycles. It waits three cycles and then writes again, so the write edge coincides with the tick that was due. It then checks two things: that the tick is missing after that edge, and that the next tick arrives one full period after the second write, not after the first.

// File: rtl/pwmtick_pkg.sv
package pwmtick_pkg;

  localparam int CODE_W = 4;

  typedef enum logic {
    CFG_PRESCALE = 1'b0,
    CFG_SELECT   = 1'b1
  } cfg_target_e;

  // divide exponent for a select code, saturated at the divider width
  function automatic int unsigned tick_shift(logic [CODE_W-1:0] code,
                                             int unsigned base,
                                             int unsigned max_shift);
    int unsigned sum;
    sum = int'(code) + base;
    return (sum > max_shift) ? max_shift : sum;
  endfunction

  // group index: 0 for the leading channels, 1 for the rest
  function automatic int unsigned group_of(int unsigned ch, int unsigned grp0_count);
    return (ch < grp0_count) ? 0 : 1;
  endfunction

  function automatic logic code_is_ext(logic [CODE_W-1:0] code,
                                       logic [(1<<CODE_W)-1:0] ext_codes);
    return ext_codes[code];
  endfunction

endpackage

// File: rtl/pwmtick_prescaler.sv
module pwmtick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] divide_m1,
  output logic             stb
);
  logic [PRE_W-1:0] cnt_q;

  assign stb = (cnt_q == divide_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (stb)          cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmtick_extsync.sv
module pwmtick_extsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_async,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ext_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/pwmtick_chan.sv
module pwmtick_chan
  import pwmtick_pkg::*;
#(
  parameter int unsigned       MAX_SHIFT = 4,
  parameter int unsigned       DIV_BASE  = 0,
  parameter logic [15:0]       EXT_CODES = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_stb,
  input  logic              ext_rise,
  input  logic [CODE_W-1:0] code,
  output logic              ext_sel,
  output logic              tick
);
  logic [MAX_SHIFT-1:0] div_q;
  logic [MAX_SHIFT-1:0] mask;
  logic                 fire;
  int unsigned          shift;

  always_comb begin
    shift = tick_shift(code, DIV_BASE, MAX_SHIFT);
    for (int i = 0; i < MAX_SHIFT; i++) mask[i] = (i < shift);
  end

  assign ext_sel = code_is_ext(code, EXT_CODES);
  assign fire    = pre_stb && ((div_q & mask) == mask) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) div_q <= '0;
    else if (pre_stb)      div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tick <= 1'b0;
    else if (ext_sel) tick <= ext_rise;
    else              tick <= fire;
  end
endmodule

// File: rtl/pwmtick_gen.sv
module pwmtick_gen
  import pwmtick_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned GRP0_CH   = 2,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned DIV_BASE  = 0,
  parameter logic [15:0] EXT_CODES = 16'h0010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_addr,
  input  logic [((2*PRE_W > CODE_W*NUM_CH) ? 2*PRE_W : CODE_W*NUM_CH)-1:0] cfg_wdata,
  input  logic [1:0] ext_i,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int PRE_BITS = 2 * PRE_W;
  localparam int SEL_BITS = CODE_W * NUM_CH;

  logic [PRE_BITS-1:0] pre_word_q;
  logic [SEL_BITS-1:0] sel_word_q;
  logic [1:0]          pre_stb;
  logic [1:0]          ext_rise;
  logic [NUM_CH-1:0]   ext_sel;
  logic                restart;

  assign restart = cfg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_word_q <= '0;
      sel_word_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_PRESCALE) pre_word_q <= cfg_wdata[PRE_BITS-1:0];
      else                          sel_word_q <= cfg_wdata[SEL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    pwmtick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .divide_m1 (pre_word_q[g*PRE_W +: PRE_W]),
      .stb       (pre_stb[g])
    );
    pwmtick_extsync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_async (ext_i[g]),
      .rise      (ext_rise[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = group_of(c, GRP0_CH);
    pwmtick_chan #(
      .MAX_SHIFT (MAX_SHIFT),
      .DIV_BASE  (DIV_BASE),
      .EXT_CODES (EXT_CODES)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .pre_stb  (pre_stb[GRP]),
      .ext_rise (ext_rise[GRP]),
      .code     (sel_word_q[c*CODE_W +: CODE_W]),
      .ext_sel  (ext_sel[c]),
      .tick     (tick_o[c])
    );
  end
endmodule

// File: rtl/pwmtick_checker.sv
module pwmtick_checker
  import pwmtick_pkg::*;
#(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned GRP0_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [NUM_CH-1:0] tick_o,
  input logic [1:0]        pre_stb,
  input logic [1:0]        ext_rise,
  input logic [NUM_CH-1:0] ext_sel
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int unsigned GRP = group_of(c, GRP0_CH);

    assert_div_tick_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[c] && !$past(ext_sel[c])) |-> $past(pre_stb[GRP]));

    assert_write_blocks_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_wr) && !$past(ext_sel[c])) |-> !tick_o[c]);

    assert_ext_tick_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[c] && $past(ext_sel[c])) |-> $past(ext_rise[GRP]));
  end

  for (genvar g = 0; g < 2; g++) begin : g_edge
    assert_ext_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise[g] |=> !ext_rise[g]);
  end
endmodule

bind pwmtick_gen pwmtick_checker #(.NUM_CH(NUM_CH), .GRP0_CH(GRP0_CH)) u_pwmtick_chk (.*);

// File: tb/test_pwmtick_gen.sv
`timescale 1ns/1ps
module test_pwmtick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic [1:0]  ext_i = '0;
  logic [4:0]  tick_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] pre_sh = '0;
  logic [19:0] sel_sh = '0;

  always #2 clk = ~clk;

  pwmtick_gen i_pwmtick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_i(ext_i), .tick_o(tick_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic int ratio(int p, int code);
    int s = (code > 4) ? 4 : code;
    return (p + 1) * (1 << s);
  endfunction

  task automatic cfg_write(bit addr, logic [19:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic measure(int ch, int expn, string tag);
    int first = 0;
    int second = 0;
    cfg_write(1'b0, {4'h0, pre_sh});
    for (int j = 1; j <= 2 * expn + 2; j++) begin
      @(negedge clk);
      if (tick_o[ch]) begin
        if (first == 0) first = j;
        else if (second == 0) second = j;
      end
    end
    check(first == expn, tag, first, expn);
    check(second - first == expn, tag, second - first, expn);
  endtask

  task automatic t_reset();
    check(tick_o == 5'b0, "R1 ticks low in reset", tick_o, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tick_o == 5'b11111, "R1 default divide by 1", tick_o, 31);
    end
  endtask

  task automatic t_prescale();
    pre_sh = {8'd4, 8'd2};
    sel_sh = '0;
    cfg_write(1'b1, sel_sh);
    measure(0, ratio(2, 0), "R2 ch0 uses p0");
    measure(1, ratio(2, 0), "R2 ch1 uses p0");
    measure(2, ratio(4, 0), "R2 ch2 uses p1");
    measure(4, ratio(4, 0), "R4 ch4 period");
  endtask

  task automatic t_select();
    pre_sh = {8'd0, 8'd1};
    sel_sh = '0;
    sel_sh[3:0]   = 4'd2;
    sel_sh[7:4]   = 4'd6;
    sel_sh[15:12] = 4'd3;
    cfg_write(1'b1, sel_sh);
    measure(0, ratio(1, 2), "R3 code 2 field 0");
    measure(1, ratio(1, 6), "R3 code 6 saturates");
    measure(3, ratio(0, 3), "R3 code 3 field 3");
    measure(2, ratio(0, 0), "R3 code 0 field 2");
  endtask

  task automatic t_ext();
    int cnt;
    sel_sh = '0;
    sel_sh[7:4]   = 4'd4;
    sel_sh[19:16] = 4'd4;
    cfg_write(1'b1, sel_sh);
    @(negedge clk); ext_i[0] = 1'b1;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      check(tick_o[1] == (j == 3), "R6 ext0 tick latency", tick_o[1], j == 3);
      check(tick_o[4] == 1'b0, "R5 ch4 ignores ext0", tick_o[4], 0);
    end
    cnt = 0;
    for (int j = 0; j < 10; j++) begin @(negedge clk); cnt += tick_o[1]; end
    check(cnt == 0, "R6 held level no tick", cnt, 0);
    ext_i[0] = 1'b0;
    cnt = 0;
    for (int j = 0; j < 8; j++) begin @(negedge clk); cnt += tick_o[1]; end
    check(cnt == 0, "R6 falling edge no tick", cnt, 0);
    ext_i[1] = 1'b1;
    cnt = 0;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      cnt += tick_o[4];
      check(tick_o[1] == 1'b0, "R5 ch1 ignores ext1", tick_o[1], 0);
    end
    check(cnt == 1, "R5 ch4 takes ext1", cnt, 1);
    ext_i[1] = 1'b0;
  endtask

  task automatic t_collide();
    int first = 0;
    pre_sh = {8'd0, 8'd3};
    sel_sh = '0;
    cfg_write(1'b1, sel_sh);
    cfg_write(1'b0, {4'h0, pre_sh});
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = {4'h0, pre_sh};
    @(negedge clk);
    cfg_wr = 1'b0;
    check(tick_o[0] == 1'b0, "R7 write suppresses due tick", tick_o[0], 0);
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (tick_o[0] && first == 0) first = j;
    end
    check(first == 4, "R7 restart from write", first, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_prescale();
    t_select();
    t_ext();
    t_collide();
    report();
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule